// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Selector

This block sits in the decode stage of a five-stage in-order pipeline and chooses the two operand values that are handed to the execute stage. For each operand it compares the decode source register ID with the destination IDs of the instructions that are still in flight. These are the execute stage (its ALU result of this cycle), the memory stage (data loaded this cycle and the latched ALU result) and the write-back stage (latched loaded data and latched ALU result). The selector then picks the value that the program would see if the instructions ran one at a time.

Operand A has one extra rule that overrides all others: when the decode instruction is a call or a jump, the incremented PC is passed on in place of any register value. Operand B uses the same register bypass chain with no such override. Register ID 0xF stands for "no register". It never produces a match, so an instruction without a destination, or a conditional move whose condition failed and which presents 0xF as its execute destination, forwards nothing. The block is purely combinational. The register file and the pipeline registers are outside it.

Top module: `fwd_bypass_sel`

## Requirements
- R1: When `decIcode` equals the call code (8) or the jump code (7), `opA` equals `decValP`, whatever register IDs match.
- R2: Otherwise `opA` takes the first matching source in this order: execute ALU result, memory loaded data, memory ALU result, write-back loaded data, write-back ALU result.
- R3: `opB` uses the same five-source order as R2 and never takes `decValP`, including when `decIcode` is 7 or 8.
- R4: When several in-flight destinations equal the same source ID, the operand takes the value from the youngest (earliest-stage) of them.
- R5: When no source matches, the operand equals its register-file read value (`regValA` / `regValB`).
- R6: A destination ID of 0xF never matches, including when the source ID is also 0xF.
- R7: The operands follow their inputs combinationally. A change of `exValE` or `memValM` appears on the operand in the same cycle, with no register in the path.
- R8: An execute destination of 0xF (a failed conditional move) lets an older matching stage supply the value.
- R9: The two operands are selected independently, so in one cycle they can come from different sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| decSrcA | input | 4 | Decode source register ID for operand A |
| decSrcB | input | 4 | Decode source register ID for operand B |
| regValA | input | 32 | Register-file read value for A |
| regValB | input | 32 | Register-file read value for B |
| decIcode | input | 4 | Decode instruction code |
| decValP | input | 32 | Incremented PC of the decode instruction |
| exDstE | input | 4 | Execute-stage ALU destination ID |
| exValE | input | 32 | Execute ALU output of this cycle |
| memDstM | input | 4 | Memory-stage load destination ID |
| memValM | input | 32 | Data read from memory this cycle |
| memDstE | input | 4 | Memory-stage ALU destination ID |
| memValE | input | 32 | Memory-stage latched ALU result |
| wbDstM | input | 4 | Write-back load destination ID |
| wbValM | input | 32 | Write-back latched loaded data |
| wbDstE | input | 4 | Write-back ALU destination ID |
| wbValE | input | 32 | Write-back latched ALU result |
| opA | output | 32 | Selected operand A |
| opB | output | 32 | Selected operand B |

## Verification
Two cases can fall in the same cycle: the PC override for operand A, and one or more register matches on the same ID. The sweep sets all five destination IDs to combinations of the two source IDs, an unrelated ID and 0xF, and rotates the instruction code through call, jump and ordinary values. A bench model then checks each operand by walking the requirement order. Directed cases put all five stages on one register and remove them one by one from the youngest. They also place a failed conditional move ahead of an older match.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  // select positions: 0 = incremented PC, 1..5 = bypass sources youngest first, 6 = register file
  localparam int NSRC = 5;
  localparam int NSEL = NSRC + 2;
  localparam int SEL_PC = 0;
  localparam int SEL_RF = NSEL - 1;

  typedef struct packed {
    logic [NSEL-1:0] selA;
    logic [NSEL-1:0] selB;
  } fwdStrobes_t;
endpackage

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int OP_W = 4,
  parameter logic [OP_W-1:0] CALL_CODE = 4'h8,
  parameter logic [OP_W-1:0] JUMP_CODE = 4'h7
) (
  input  logic [REG_W-1:0] srcA,
  input  logic [REG_W-1:0] srcB,
  input  logic [OP_W-1:0]  icode,
  input  logic [REG_W-1:0] dstIds [NSRC],
  output fwdStrobes_t      strobes
);
  localparam logic [REG_W-1:0] NO_REG = {REG_W{1'b1}};

  logic [NSRC-1:0] hitA, hitB;
  logic usePc;

  assign usePc = (icode == CALL_CODE) || (icode == JUMP_CODE);

  for (genvar s = 0; s < NSRC; s++) begin : g_cmp
    assign hitA[s] = (dstIds[s] != NO_REG) && (dstIds[s] == srcA);
    assign hitB[s] = (dstIds[s] != NO_REG) && (dstIds[s] == srcB);
  end

  function automatic logic [NSEL-1:0] pickFirst(input logic [NSRC-1:0] hits, input logic pcOverride);
    logic [NSEL-1:0] sel;
    logic found;
    sel = '0;
    found = pcOverride;
    if (pcOverride) sel[SEL_PC] = 1'b1;
    for (int s = 0; s < NSRC; s++) begin
      if (!found && hits[s]) begin
        sel[s+1] = 1'b1;
        found = 1'b1;
      end
    end
    if (!found) sel[SEL_RF] = 1'b1;
    return sel;
  endfunction

  always_comb begin
    strobes.selA = pickFirst(hitA, usePc);
    strobes.selB = pickFirst(hitB, 1'b0);
  end
endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwdStrobes_t       strobes,
  input  logic [DATA_W-1:0] valP,
  input  logic [DATA_W-1:0] rfA,
  input  logic [DATA_W-1:0] rfB,
  input  logic [DATA_W-1:0] srcVals [NSRC],
  output logic [DATA_W-1:0] outA,
  output logic [DATA_W-1:0] outB
);
  logic [DATA_W-1:0] candA [NSEL];
  logic [DATA_W-1:0] candB [NSEL];

  assign candA[SEL_PC] = valP;
  assign candB[SEL_PC] = '0;
  assign candA[SEL_RF] = rfA;
  assign candB[SEL_RF] = rfB;
  for (genvar s = 0; s < NSRC; s++) begin : g_cand
    assign candA[s+1] = srcVals[s];
    assign candB[s+1] = srcVals[s];
  end

  always_comb begin
    outA = '0;
    outB = '0;
    for (int i = 0; i < NSEL; i++) begin
      outA = outA | ({DATA_W{strobes.selA[i]}} & candA[i]);
      outB = outB | ({DATA_W{strobes.selB[i]}} & candB[i]);
    end
  end
endmodule

// File: rtl/fwd_bypass_sel.sv
module fwd_bypass_sel
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W = 4,
  parameter int OP_W = 4
) (
  input  logic [REG_W-1:0]  decSrcA,
  input  logic [REG_W-1:0]  decSrcB,
  input  logic [DATA_W-1:0] regValA,
  input  logic [DATA_W-1:0] regValB,
  input  logic [OP_W-1:0]   decIcode,
  input  logic [DATA_W-1:0] decValP,
  input  logic [REG_W-1:0]  exDstE,
  input  logic [DATA_W-1:0] exValE,
  input  logic [REG_W-1:0]  memDstM,
  input  logic [DATA_W-1:0] memValM,
  input  logic [REG_W-1:0]  memDstE,
  input  logic [DATA_W-1:0] memValE,
  input  logic [REG_W-1:0]  wbDstM,
  input  logic [DATA_W-1:0] wbValM,
  input  logic [REG_W-1:0]  wbDstE,
  input  logic [DATA_W-1:0] wbValE,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB
);
  logic [REG_W-1:0]  dstIds  [NSRC];
  logic [DATA_W-1:0] srcVals [NSRC];
  fwdStrobes_t strobes;

  // youngest first: this order is the bypass priority
  assign dstIds[0] = exDstE;   assign srcVals[0] = exValE;
  assign dstIds[1] = memDstM;  assign srcVals[1] = memValM;
  assign dstIds[2] = memDstE;  assign srcVals[2] = memValE;
  assign dstIds[3] = wbDstM;   assign srcVals[3] = wbValM;
  assign dstIds[4] = wbDstE;   assign srcVals[4] = wbValE;

  fwd_ctrl #(.REG_W(REG_W), .OP_W(OP_W)) u_ctrl (
    .srcA(decSrcA), .srcB(decSrcB), .icode(decIcode),
    .dstIds(dstIds), .strobes(strobes)
  );

  fwd_datapath #(.DATA_W(DATA_W)) u_dp (
    .strobes(strobes), .valP(decValP), .rfA(regValA), .rfB(regValB),
    .srcVals(srcVals), .outA(opA), .outB(opB)
  );
endmodule

// File: rtl/fwd_bypass_sel_chk.sv
module fwd_bypass_sel_chk
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W = 4,
  parameter int OP_W = 4
) (
  input logic [REG_W-1:0]  decSrcA,
  input logic [REG_W-1:0]  decSrcB,
  input logic [DATA_W-1:0] regValA,
  input logic [DATA_W-1:0] regValB,
  input logic [OP_W-1:0]   decIcode,
  input logic [DATA_W-1:0] decValP,
  input logic [REG_W-1:0]  exDstE,
  input logic [DATA_W-1:0] exValE,
  input logic [REG_W-1:0]  memDstM,
  input logic [REG_W-1:0]  memDstE,
  input logic [REG_W-1:0]  wbDstM,
  input logic [REG_W-1:0]  wbDstE,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input fwdStrobes_t       strobes
);
  localparam logic [REG_W-1:0] NO_REG = {REG_W{1'b1}};
  logic pcOp;
  assign pcOp = (decIcode == OP_W'(8)) || (decIcode == OP_W'(7));

  always_comb begin
    a_r2_one_sel_a: assert ($onehot(strobes.selA));
    a_r3_one_sel_b: assert ($onehot(strobes.selB) && !strobes.selB[SEL_PC]);
    if (pcOp) a_r1_pc_override: assert (opA == decValP);
    if (!pcOp && exDstE != NO_REG && exDstE == decSrcA)
      a_r4_youngest_a: assert (opA == exValE);
    if (decSrcB == NO_REG) a_r6_none_b: assert (opB == regValB);
    if (exDstE != decSrcB && memDstM != decSrcB && memDstE != decSrcB &&
        wbDstM != decSrcB && wbDstE != decSrcB)
      a_r5_rf_b: assert (opB == regValB);
  end
endmodule

bind fwd_bypass_sel fwd_bypass_sel_chk #(.DATA_W(DATA_W), .REG_W(REG_W), .OP_W(OP_W)) u_chk (
  .decSrcA(decSrcA), .decSrcB(decSrcB), .regValA(regValA), .regValB(regValB),
  .decIcode(decIcode), .decValP(decValP), .exDstE(exDstE), .exValE(exValE),
  .memDstM(memDstM), .memDstE(memDstE), .wbDstM(wbDstM), .wbDstE(wbDstE),
  .opA(opA), .opB(opB), .strobes(strobes)
);

// File: tb/fwd_bypass_sel_tb.sv
module fwd_bypass_sel_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]  decSrcA, decSrcB, decIcode;
  logic [31:0] regValA, regValB, decValP;
  logic [3:0]  exDstE, memDstM, memDstE, wbDstM, wbDstE;
  logic [31:0] exValE, memValM, memValE, wbValM, wbValE;
  logic [31:0] opA, opB;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  fwd_bypass_sel u_dut (
    .decSrcA(decSrcA), .decSrcB(decSrcB), .regValA(regValA), .regValB(regValB),
    .decIcode(decIcode), .decValP(decValP),
    .exDstE(exDstE), .exValE(exValE), .memDstM(memDstM), .memValM(memValM),
    .memDstE(memDstE), .memValE(memValE), .wbDstM(wbDstM), .wbValM(wbValM),
    .wbDstE(wbDstE), .wbValE(wbValE), .opA(opA), .opB(opB)
  );

  function automatic logic [31:0] model(input logic [3:0] src, input logic isA);
    if (isA && (decIcode == 4'd7 || decIcode == 4'd8)) return decValP;
    if (exDstE  != 4'hF && exDstE  == src) return exValE;
    if (memDstM != 4'hF && memDstM == src) return memValM;
    if (memDstE != 4'hF && memDstE == src) return memValE;
    if (wbDstM  != 4'hF && wbDstM  == src) return wbValM;
    if (wbDstE  != 4'hF && wbDstE  == src) return wbValE;
    return isA ? regValA : regValB;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    decSrcA = 4'd1; decSrcB = 4'd2; decIcode = 4'd0;
    regValA = 32'hAAAA0001; regValB = 32'hBBBB0002; decValP = 32'h00000100;
    exDstE = 4'hF; memDstM = 4'hF; memDstE = 4'hF; wbDstM = 4'hF; wbDstE = 4'hF;
    exValE = 32'h11110000; memValM = 32'h22220000; memValE = 32'h33330000;
    wbValM = 32'h44440000; wbValE = 32'h55550000;
  endtask

  function automatic logic [3:0] pickId(input int code, input logic [3:0] a, input logic [3:0] b);
    case (code)
      0: return a;
      1: return b;
      2: return 4'(a + 4'd5);
      default: return 4'hF;
    endcase
  endfunction

  initial begin
    #(4 * 190000);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    idle();
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R5 idle A", opA, 32'hAAAA0001);
    check("R5 idle B", opB, 32'hBBBB0002);

    // R4: all stages write A's register; peel off youngest one at a time
    @(posedge clk);
    exDstE = 4'd1; memDstM = 4'd1; memDstE = 4'd1; wbDstM = 4'd1; wbDstE = 4'd1;
    @(negedge clk); check("R4 ex", opA, 32'h11110000);
    @(posedge clk); exDstE = 4'hF;
    @(negedge clk); check("R4 memM", opA, 32'h22220000);
    @(posedge clk); memDstM = 4'hF;
    @(negedge clk); check("R4 memE", opA, 32'h33330000);
    @(posedge clk); memDstE = 4'hF;
    @(negedge clk); check("R4 wbM", opA, 32'h44440000);
    @(posedge clk); wbDstM = 4'hF;
    @(negedge clk); check("R4 wbE", opA, 32'h55550000);
    check("R5 B untouched", opB, 32'hBBBB0002);

    // R8: failed conditional move in execute, older memory match wins
    @(posedge clk); idle(); exDstE = 4'hF; memDstE = 4'd1;
    @(negedge clk); check("R8 cmov", opA, 32'h33330000);

    // R6: none ID with all destinations none
    @(posedge clk); idle(); decSrcA = 4'hF; decSrcB = 4'hF;
    @(negedge clk); check("R6 A", opA, 32'hAAAA0001); check("R6 B", opB, 32'hBBBB0002);

    // R1 and R3: call/jump with matches on both operands
    @(posedge clk); idle(); decIcode = 4'd8; exDstE = 4'd1; memDstM = 4'd2;
    @(negedge clk); check("R1 call A", opA, 32'h00000100); check("R3 call B", opB, 32'h22220000);
    @(posedge clk); decIcode = 4'd7;
    @(negedge clk); check("R1 jump A", opA, 32'h00000100); check("R3 jump B", opB, 32'h22220000);

    // R9: different sources for A and B
    @(posedge clk); idle(); wbDstE = 4'd1; exDstE = 4'd2;
    @(negedge clk); check("R9 A", opA, 32'h55550000); check("R9 B", opB, 32'h11110000);

    // R7: value changes within the cycle, no register delay
    @(posedge clk); idle(); exDstE = 4'd1; memDstM = 4'd2;
    @(negedge clk); exValE = 32'hCAFE0007; memValM = 32'hBEEF0007;
    #1; check("R7 ex", opA, 32'hCAFE0007); check("R7 memM", opB, 32'hBEEF0007);

    // R2/R3 sweep
    for (int sa = 0; sa < 16; sa++) begin
      for (int k = 0; k < 3; k++) begin
        for (int combo = 0; combo < 1024; combo++) begin
          @(posedge clk);
          decSrcA = 4'(sa);
          decSrcB = 4'(sa + 3 * k);
          case (combo % 4)
            0: decIcode = 4'd8;
            1: decIcode = 4'd7;
            2: decIcode = 4'd2;
            default: decIcode = 4'd6;
          endcase
          exDstE  = pickId(combo & 3, decSrcA, decSrcB);
          memDstM = pickId((combo >> 2) & 3, decSrcA, decSrcB);
          memDstE = pickId((combo >> 4) & 3, decSrcA, decSrcB);
          wbDstM  = pickId((combo >> 6) & 3, decSrcA, decSrcB);
          wbDstE  = pickId((combo >> 8) & 3, decSrcA, decSrcB);
          exValE  = 32'h10000000 + 32'(combo);
          memValM = 32'h20000000 + 32'(sa);
          memValE = 32'h30000000 + 32'(k);
          wbValM  = 32'h40000000 + 32'(combo);
          wbValE  = 32'h50000000 + 32'(sa);
          regValA = 32'hA0000000 + 32'(combo);
          regValB = 32'hB0000000 + 32'(combo);
          decValP = 32'hC0000000 + 32'(combo);
          @(negedge clk);
          check("R2 sweep A", opA, model(decSrcA, 1'b1));
          check("R3 sweep B", opB, model(decSrcB, 1'b0));
        end
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule